// File: doc/BRIEF.md
# Serial Port FIFO Status Unit

This unit sits between the register interface of a synchronous serial port and its shifter. It keeps two first-in first-out buffers. The transmit buffer is filled by processor or DMA writes and drained by the shifter. The receive buffer is filled by the shifter and drained by processor reads. From the buffer levels, the port enable and the shifter's frame activity, it builds a packed status byte. It also raises a transmit service request whenever the transmit buffer runs low.

The service request goes to exactly one place: the interrupt line or the transmit DMA request line. Software picks the target with two enable bits. Setting both enable bits is a programming mistake. In that case neither request line is driven and a configuration error output is raised instead. When the port is disabled, the service flag, the busy flag and both request lines are held low. The buffer contents are left as they are.

Every flag and request output is registered. Each one follows the buffer levels and inputs with one clock of delay.

Top module: `spfifo_status`

## Requirements
- R1: While and directly after synchronous reset, the status byte reads 0x04 (only transmit-not-full set), and `irq`, `tx_dma_req` and `cfg_err` are 0. Both buffers are empty.
- R2: Status bit 5 (transmit service) is 1 exactly when the port is enabled and the transmit level is less than or equal to `tx_thresh`, sampled one clock after the level or threshold changes.
- R3: `irq` is 1 exactly when status bit 5 is 1, `tx_irq_en` is 1 and `tx_dma_en` is 0.
- R4: `tx_dma_req` is 1 exactly when status bit 5 is 1, `tx_dma_en` is 1 and `tx_irq_en` is 0.
- R5: When `tx_irq_en` and `tx_dma_en` are both 1, `cfg_err` is 1 one clock later, and `irq` and `tx_dma_req` are both 0.
- R6: While `port_en` is 0, status bits 5 and 4, `irq` and `tx_dma_req` read 0 one clock later, whatever the transmit level or frame activity.
- R7: Status bit 4 (busy) is `frame_active` AND `port_en`, delayed by one clock. It never drives `irq`.
- R8: Status bit 3 (receive-not-empty) is 1 when the receive buffer holds at least one entry and 0 when it is empty.
- R9: Status bit 2 (transmit-not-full) is 0 only when the transmit buffer holds all DEPTH entries, and 1 otherwise.
- R10: A write to a full transmit buffer is ignored: the level and the stored words stay unchanged.
- R11: A read from an empty receive buffer is ignored: the level stays 0, and a later push followed by a read returns the pushed word.
- R12: Both buffers return words in the order they were stored, with the head word visible on the read-data port before it is popped.
- R13: Status bits 1:0 and 7:6 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | 1 | Port enable |
| tx_irq_en | input | 1 | Route transmit service to interrupt |
| tx_dma_en | input | 1 | Route transmit service to DMA request |
| tx_thresh | input | TW | Inclusive transmit trigger threshold |
| frame_active | input | 1 | Shifter is moving a frame |
| tx_wr | input | 1 | Write one word into the transmit buffer |
| tx_wr_data | input | DW | Word to write |
| tx_pop | input | 1 | Shifter takes the head transmit word |
| tx_pop_data | output | DW | Head transmit word |
| rx_push | input | 1 | Shifter stores one received word |
| rx_push_data | input | DW | Received word |
| rx_rd | input | 1 | Read the head receive word |
| rx_rd_data | output | DW | Head receive word |
| status | output | 8 | Packed status byte |
| irq | output | 1 | Transmit service interrupt |
| tx_dma_req | output | 1 | Transmit DMA request |
| cfg_err | output | 1 | Both request enables set |

## Verification
The transmit path is swept over every threshold from 0 to 15. For each threshold the buffer is filled from empty to full and then drained. This locates the inclusive boundary at level equal to threshold, separating it from a strict compare, and also exercises the full edge of the not-full flag. All four combinations of the two enables are applied with the service flag set, so the interrupt, DMA and conflict routes can each be told apart. Disable, busy, overfill and underread patterns isolate the forcing rules and the ignored-access rules. Every pop is checked for order.

// File: rtl/spfs_pkg.sv
package spfs_pkg;
    localparam int DEPTH   = 16;
    localparam int DW      = 8;
    localparam int TW      = 4;
    localparam int SW      = 8;
    localparam int BIT_TNF = 2;
    localparam int BIT_RNE = 3;
    localparam int BIT_BSY = 4;
    localparam int BIT_TSV = 5;

    typedef struct packed {
        logic tsvc;
        logic busy;
        logic rne;
        logic tnf;
    } flags_t;

    typedef enum logic [1:0] {
        ROUTE_NONE,
        ROUTE_IRQ,
        ROUTE_DMA,
        ROUTE_CLASH
    } route_e;

    function automatic route_e route_of(input logic irq_en, input logic dma_en);
        case ({irq_en, dma_en})
            2'b10:   return ROUTE_IRQ;
            2'b01:   return ROUTE_DMA;
            2'b11:   return ROUTE_CLASH;
            default: return ROUTE_NONE;
        endcase
    endfunction

    function automatic logic [SW-1:0] pack_status(input flags_t f);
        logic [SW-1:0] s;
        s          = '0;
        s[BIT_TNF] = f.tnf;
        s[BIT_RNE] = f.rne;
        s[BIT_BSY] = f.busy;
        s[BIT_TSV] = f.tsvc;
        return s;
    endfunction
endpackage

// File: rtl/spfs_fifo.sv
module spfs_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] pop_data,
    output logic [LW-1:0] level
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          full, empty, do_push, do_pop;

    assign full     = (level == LW'(DEPTH));
    assign empty    = (level == '0);
    assign do_push  = push && !full;
    assign do_pop   = pop && !empty;
    assign pop_data = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (do_push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/spfs_flags.sv
module spfs_flags
    import spfs_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int TW    = 4,
    localparam int LW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [LW-1:0] tx_level,
    input  logic [LW-1:0] rx_level,
    input  logic [TW-1:0] thresh,
    input  logic          port_en,
    input  logic          frame_active,
    input  logic          irq_en,
    input  logic          dma_en,
    output flags_t        flags_q,
    output logic          irq_q,
    output logic          dma_q,
    output logic          clash_q
);
    flags_t nxt;
    route_e route;

    always_comb begin
        nxt.tnf  = (tx_level != LW'(DEPTH));
        nxt.rne  = (rx_level != '0);
        nxt.busy = port_en && frame_active;
        nxt.tsvc = port_en && (tx_level <= LW'(thresh));
        route    = route_of(irq_en, dma_en);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '{tsvc: 1'b0, busy: 1'b0, rne: 1'b0, tnf: 1'b1};
            irq_q   <= 1'b0;
            dma_q   <= 1'b0;
            clash_q <= 1'b0;
        end else begin
            flags_q <= nxt;
            irq_q   <= nxt.tsvc && (route == ROUTE_IRQ);
            dma_q   <= nxt.tsvc && (route == ROUTE_DMA);
            clash_q <= (route == ROUTE_CLASH);
        end
    end
endmodule

// File: rtl/spfifo_status.sv
module spfifo_status
    import spfs_pkg::*;
#(
    parameter int DEPTH = spfs_pkg::DEPTH,
    parameter int DW    = spfs_pkg::DW,
    parameter int TW    = spfs_pkg::TW,
    localparam int LW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          port_en,
    input  logic          tx_irq_en,
    input  logic          tx_dma_en,
    input  logic [TW-1:0] tx_thresh,
    input  logic          frame_active,
    input  logic          tx_wr,
    input  logic [DW-1:0] tx_wr_data,
    input  logic          tx_pop,
    output logic [DW-1:0] tx_pop_data,
    input  logic          rx_push,
    input  logic [DW-1:0] rx_push_data,
    input  logic          rx_rd,
    output logic [DW-1:0] rx_rd_data,
    output logic [SW-1:0] status,
    output logic          irq,
    output logic          tx_dma_req,
    output logic          cfg_err
);
    logic [LW-1:0] tx_level, rx_level;
    flags_t        flags;

    spfs_fifo #(.DEPTH(DEPTH), .DW(DW)) i_txq (
        .clk(clk), .rst(rst),
        .push(tx_wr), .push_data(tx_wr_data),
        .pop(tx_pop), .pop_data(tx_pop_data),
        .level(tx_level)
    );

    spfs_fifo #(.DEPTH(DEPTH), .DW(DW)) i_rxq (
        .clk(clk), .rst(rst),
        .push(rx_push), .push_data(rx_push_data),
        .pop(rx_rd), .pop_data(rx_rd_data),
        .level(rx_level)
    );

    spfs_flags #(.DEPTH(DEPTH), .TW(TW)) i_flags (
        .clk(clk), .rst(rst),
        .tx_level(tx_level), .rx_level(rx_level),
        .thresh(tx_thresh), .port_en(port_en),
        .frame_active(frame_active),
        .irq_en(tx_irq_en), .dma_en(tx_dma_en),
        .flags_q(flags), .irq_q(irq), .dma_q(tx_dma_req),
        .clash_q(cfg_err)
    );

    assign status = pack_status(flags);
endmodule

// File: rtl/spfs_chk.sv
module spfs_chk (
    input logic       clk,
    input logic       rst,
    input logic       port_en,
    input logic       irq_en,
    input logic       dma_en,
    input logic       frame_active,
    input logic [7:0] status,
    input logic       irq,
    input logic       dma_req,
    input logic       cfg_err
);
    // R3
    irq_needs_service_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (status[5] && !dma_req));

    // R4
    dma_needs_service_chk: assert property (@(posedge clk) disable iff (rst)
        dma_req |-> (status[5] && !irq));

    // R5
    both_enables_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_en && dma_en) |=> (cfg_err && !irq && !dma_req));

    // R6
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !port_en |=> (!status[5] && !status[4] && !irq && !dma_req));

    // R7
    idle_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_active |=> !status[4]);
endmodule

bind spfifo_status spfs_chk i_spfs_chk (
    .clk(clk), .rst(rst), .port_en(port_en),
    .irq_en(tx_irq_en), .dma_en(tx_dma_en),
    .frame_active(frame_active), .status(status),
    .irq(irq), .dma_req(tx_dma_req), .cfg_err(cfg_err)
);

// File: tb/test_spfifo_status.sv
module test_spfifo_status;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst, port_en, tx_irq_en, tx_dma_en, frame_active;
    logic [3:0] tx_thresh;
    logic       tx_wr, tx_pop, rx_push, rx_rd;
    logic [7:0] tx_wr_data, rx_push_data, tx_pop_data, rx_rd_data, status;
    logic       irq, tx_dma_req, cfg_err;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spfifo_status i_spfifo_status (
        .clk(clk), .rst(rst), .port_en(port_en),
        .tx_irq_en(tx_irq_en), .tx_dma_en(tx_dma_en),
        .tx_thresh(tx_thresh), .frame_active(frame_active),
        .tx_wr(tx_wr), .tx_wr_data(tx_wr_data),
        .tx_pop(tx_pop), .tx_pop_data(tx_pop_data),
        .rx_push(rx_push), .rx_push_data(rx_push_data),
        .rx_rd(rx_rd), .rx_rd_data(rx_rd_data),
        .status(status), .irq(irq), .tx_dma_req(tx_dma_req),
        .cfg_err(cfg_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            summary();
        end
    end

    // Expected transmit flags at a given level; R13 reserved bits checked too
    task automatic chk_tx(input int lvl, input int thr, input bit ie, input bit de);
        bit tsv;
        tsv = (lvl <= thr);
        chk(status[5] == tsv, "R2", status[5], tsv);
        chk(status[2] == (lvl < DEPTH), "R9", status[2], lvl < DEPTH);
        chk(irq == (tsv && ie && !de), "R3", irq, tsv && ie && !de);
        chk(tx_dma_req == (tsv && de && !ie), "R4", tx_dma_req, tsv && de && !ie);
        chk(status[1:0] == 2'b00 && status[7:6] == 2'b00, "R13", status, status & 8'h3c);
    endtask

    initial begin
        rst = 1; port_en = 0; tx_irq_en = 0; tx_dma_en = 0; frame_active = 0;
        tx_thresh = 0; tx_wr = 0; tx_pop = 0; rx_push = 0; rx_rd = 0;
        tx_wr_data = 0; rx_push_data = 0;
        tick(); tick();
        chk(status == 8'h04, "R1", status, 8'h04);
        chk(!irq && !tx_dma_req && !cfg_err, "R1", {irq, tx_dma_req, cfg_err}, 0);
        rst = 0;
        tick();
        chk(status == 8'h04, "R1", status, 8'h04);

        // threshold sweep with interrupt routing, fill and drain (R2 R3 R9 R10 R12)
        port_en = 1; tx_irq_en = 1;
        for (int thr = 0; thr < 16; thr++) begin
            tx_thresh = 4'(thr);
            tick();
            chk_tx(0, thr, 1, 0);
            for (int n = 1; n <= DEPTH + 1; n++) begin
                tx_wr = 1; tx_wr_data = 8'((thr * 17 + n) & 255);
                tick();
                tx_wr = 0;
                tick();
                chk_tx((n > DEPTH) ? DEPTH : n, thr, 1, 0);
            end
            for (int n = 1; n <= DEPTH; n++) begin
                chk(tx_pop_data == 8'((thr * 17 + n) & 255), "R10 R12 order",
                    tx_pop_data, (thr * 17 + n) & 255);
                tx_pop = 1;
                tick();
                tx_pop = 0;
            end
            tick();
            chk_tx(0, thr, 1, 0);
        end

        // routing combinations with service active (level 0, thr 0)
        tx_thresh = 0;
        for (int m = 0; m < 4; m++) begin
            tx_irq_en = m[0]; tx_dma_en = m[1];
            tick();
            chk_tx(0, 0, m[0], m[1]);
            chk(cfg_err == (m == 3), "R5", cfg_err, m == 3);
        end
        tx_irq_en = 0; tx_dma_en = 1;

        // busy follows frame activity one clock later (R7)
        frame_active = 1;
        tick();
        chk(status[4] == 1, "R7", status[4], 1);
        chk(tx_dma_req == 1 && irq == 0, "R7 no irq", irq, 0);
        frame_active = 0;
        tick();
        chk(status[4] == 0, "R7", status[4], 0);

        // disabled port forces service, busy and requests low (R6)
        frame_active = 1; port_en = 0; tx_irq_en = 1; tx_dma_en = 0;
        tick();
        chk(status[5] == 0 && status[4] == 0, "R6", status[5:4], 0);
        chk(irq == 0 && tx_dma_req == 0, "R6", {irq, tx_dma_req}, 0);
        port_en = 1; frame_active = 0;
        tick();
        chk(irq == 1, "R6 release", irq, 1);

        // receive path: read when empty, fill, overfill, drain (R8 R11 R12)
        rx_rd = 1;
        tick();
        rx_rd = 0;
        tick();
        chk(status[3] == 0, "R11", status[3], 0);
        for (int n = 0; n <= DEPTH; n++) begin
            rx_push = 1; rx_push_data = 8'(8'hA0 + n);
            tick();
            rx_push = 0;
            tick();
            chk(status[3] == 1, "R8", status[3], 1);
        end
        for (int n = 0; n < DEPTH; n++) begin
            chk(rx_rd_data == 8'(8'hA0 + n), "R12 rx order", rx_rd_data, 8'hA0 + n);
            rx_rd = 1;
            tick();
            rx_rd = 0;
            tick();
            chk(status[3] == (n < DEPTH - 1), "R8", status[3], n < DEPTH - 1);
        end
        rx_rd = 1;
        tick();
        rx_rd = 0;
        rx_push = 1; rx_push_data = 8'h5C;
        tick();
        rx_push = 0;
        tick();
        chk(status[3] == 1, "R11", status[3], 1);
        chk(rx_rd_data == 8'h5C, "R11", rx_rd_data, 8'h5C);
        rx_rd = 1;
        tick();
        rx_rd = 0;
        tick();
        chk(status[3] == 0, "R11", status[3], 0);

        summary();
    end
endmodule